// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a countdown watchdog that software controls through a small 32-bit register port. Software loads a reload value, turns the counter on through a control word, and must keep restarting the countdown by writing a fixed 16-bit key to a restart location. If software stops servicing the timer and the count runs out, the block emits a one-cycle reset request.

An external hold input suppresses that request. When hold is high at the moment of expiry, the block clears its own control word instead of asking for a reset, so the watchdog switches itself off. The countdown runs on one of two sources. It either steps once per peripheral clock or once per pulse on a 1 MHz tick input, and a control bit picks between them. The current count can be read back on a dedicated port and through the register port.

Top module: `kwdog_top`

## Requirements
- R1: After reset the count and the reload register both hold 0x03EF1480, the control word reads 0 and the reset request is low.
- R2: A write to byte offset 0x04 stores the full word as the reload value. Writes to offset 0x00 (the count) are ignored. Reads return the count at 0x00, the reload at 0x04 and the control word at 0x0C, and return 0 at offset 0x08 and at every other offset.
- R3: A write to offset 0x08 whose bits [15:0] equal 0x4755 loads the count from the reload register and re-arms expiry. A write there with any other low half changes nothing.
- R4: The control word at 0x0C keeps bits [5:0]: bit 0 enables counting, bit 4 selects the 1 MHz tick, and bits 1, 2, 3 and 5 are stored for read-back only. Upper bits read 0. A control write takes effect only if its bit 0 differs from the current enable; otherwise the control word stays unchanged.
- R5: A control write that enables the timer loads the count from the reload value. A control write that disables it freezes the count at its current value.
- R6: While enabled, the count drops by one on every clock when bit 4 is 0, and only on clocks where the 1 MHz tick input is high when bit 4 is 1. While disabled, the count does not change.
- R7: When the count steps from 1 to 0 with hold low, the reset request is high for exactly one cycle, in the same cycle that the count first reads 0. The count then stays at 0 until a restart or a re-enable.
- R8: When the count steps from 1 to 0 with hold high, the control word is cleared to 0 and no reset request is raised.
- R9: An accepted restart, or a control write that flips the enable, takes precedence over a count step in the same cycle. No expiry can then occur in that cycle.
- R10: When the reload value is 0, a restart or an enable loads 0 and no reset request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 5 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_1mhz | input | 1 | One-cycle pulses at 1 MHz |
| hold_in | input | 1 | When high at expiry, the block disables itself instead of requesting a reset |
| wd_reset_req | output | 1 | One-cycle reset request on expiry |
| count_value | output | 32 | Current count |

## Verification
The bench targets the cycle where a count step meets a register write. A restart or disabling write that lands on the final step must win. A design that applied the step first would emit a spurious reset pulse or lose a count. Control writes that repeat the current enable are probed, because a design that stored them would restart or corrupt the countdown. The bench covers hold at expiry, a reload of zero and the tick-selected mode. A design that got these wrong would fire a reset while hold is high, pulse on a zero reload, or count on every clock while the 1 MHz source is selected.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;
    localparam int unsigned CSR_W     = 32;
    localparam int unsigned CTRL_W    = 6;
    localparam int unsigned KEY_W     = 16;
    localparam logic [KEY_W-1:0] RESTART_KEY = 16'h4755;
    localparam logic [CSR_W-1:0] RESET_LOAD  = 32'h03EF1480;

    // byte offsets of the register port
    localparam logic [4:0] OFS_COUNT   = 5'h00;
    localparam logic [4:0] OFS_RELOAD  = 5'h04;
    localparam logic [4:0] OFS_RESTART = 5'h08;
    localparam logic [4:0] OFS_CTRL    = 5'h0C;

    // control word bit positions
    localparam int unsigned CB_ENABLE  = 0;
    localparam int unsigned CB_TICKSEL = 4;

    typedef struct packed {
        logic we_reload;
        logic we_restart;
        logic we_ctrl;
    } wr_strobe_t;
endpackage

// File: rtl/kwdog_regif.sv
module kwdog_regif
    import kwdog_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CSR_W-1:0]  count_q,
    input  logic [CSR_W-1:0]  reload_q,
    input  logic [CTRL_W-1:0] ctrl_q,
    output wr_strobe_t        strobe,
    output logic [CSR_W-1:0]  bus_rdata
);
    localparam int unsigned PAD_W = CSR_W - CTRL_W;

    logic [4:0] ofs;
    always_comb begin
        ofs = 5'(bus_addr);
    end

    always_comb begin
        strobe.we_reload  = bus_wr && (ofs == OFS_RELOAD);
        strobe.we_restart = bus_wr && (ofs == OFS_RESTART);
        strobe.we_ctrl    = bus_wr && (ofs == OFS_CTRL);
    end

    always_comb begin
        unique case (ofs)
            OFS_COUNT:  bus_rdata = count_q;
            OFS_RELOAD: bus_rdata = reload_q;
            OFS_CTRL:   bus_rdata = {{PAD_W{1'b0}}, ctrl_q};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/kwdog_core.sv
module kwdog_core
    import kwdog_pkg::*;
#(
    parameter logic [CSR_W-1:0] INIT_LOAD = RESET_LOAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_strobe_t        strobe,
    input  logic [CSR_W-1:0]  wdata,
    input  logic              tick_1mhz,
    input  logic              hold_in,
    output logic [CSR_W-1:0]  count_q,
    output logic [CSR_W-1:0]  reload_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              reset_req_q
);
    typedef struct packed {
        logic [CSR_W-1:0]  count;
        logic [CSR_W-1:0]  reload;
        logic [CTRL_W-1:0] ctrl;
        logic              armed;
        logic              req;
    } st_t;

    st_t st_q, st_d;
    logic step, key_ok, flip;

    always_comb begin
        step   = st_q.ctrl[CB_ENABLE] && st_q.armed &&
                 (st_q.ctrl[CB_TICKSEL] ? tick_1mhz : 1'b1);
        key_ok = strobe.we_restart && (wdata[KEY_W-1:0] == RESTART_KEY);
        flip   = strobe.we_ctrl && (wdata[CB_ENABLE] != st_q.ctrl[CB_ENABLE]);

        st_d     = st_q;
        st_d.req = 1'b0;

        if (step) begin
            st_d.count = st_q.count - 1'b1;
            if (st_q.count == 1) begin
                st_d.armed = 1'b0;
                if (hold_in) st_d.ctrl = '0;
                else         st_d.req  = 1'b1;
            end
        end

        if (strobe.we_reload) st_d.reload = wdata;

        if (key_ok) begin
            st_d.count = st_q.reload;
            st_d.armed = (st_q.reload != 0);
            st_d.ctrl  = st_q.ctrl;
            st_d.req   = 1'b0;
        end else if (flip) begin
            st_d.ctrl = wdata[CTRL_W-1:0];
            st_d.req  = 1'b0;
            if (wdata[CB_ENABLE]) begin
                st_d.count = st_q.reload;
                st_d.armed = (st_q.reload != 0);
            end else begin
                st_d.count = st_q.count;
                st_d.armed = st_q.armed;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{count: INIT_LOAD, reload: INIT_LOAD, ctrl: '0,
                      armed: 1'b1, req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q     = st_q.count;
    assign reload_q    = st_q.reload;
    assign ctrl_q      = st_q.ctrl;
    assign reset_req_q = st_q.req;

    // R7: request lasts one cycle and coincides with a zero count
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_q |=> !reset_req_q);
    a_r7_zero_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_q |-> (count_q == 0));
    // R8: no request may follow expiry with hold high
    a_r8_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_q |-> !$past(hold_in));
    // R6: disabled with no write -> count frozen
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctrl_q[CB_ENABLE]) && !$past(strobe.we_ctrl) &&
         !$past(strobe.we_restart)) |-> $stable(count_q));
    // R3: bad key on a disabled timer leaves the count alone
    a_r3_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strobe.we_restart) && ($past(wdata[KEY_W-1:0]) != RESTART_KEY) &&
         !$past(ctrl_q[CB_ENABLE])) |-> $stable(count_q));
    // R4: a control write that repeats the enable is discarded
    a_r4_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(strobe.we_ctrl) && ($past(wdata[CB_ENABLE]) == $past(ctrl_q[CB_ENABLE])) &&
         ($past(count_q) != 1)) |-> $stable(ctrl_q));
    // strobes decoded from one address are exclusive
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({strobe.we_reload, strobe.we_restart, strobe.we_ctrl}));
endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
    import kwdog_pkg::*;
#(
    parameter int unsigned      ADDR_W    = 5,
    parameter logic [CSR_W-1:0] INIT_LOAD = RESET_LOAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CSR_W-1:0]  bus_wdata,
    output logic [CSR_W-1:0]  bus_rdata,
    input  logic              tick_1mhz,
    input  logic              hold_in,
    output logic              wd_reset_req,
    output logic [CSR_W-1:0]  count_value
);
    wr_strobe_t        strobe;
    logic [CSR_W-1:0]  count_q, reload_q;
    logic [CTRL_W-1:0] ctrl_q;

    kwdog_regif #(.ADDR_W(ADDR_W)) regif_i (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .count_q   (count_q),
        .reload_q  (reload_q),
        .ctrl_q    (ctrl_q),
        .strobe    (strobe),
        .bus_rdata (bus_rdata)
    );

    kwdog_core #(.INIT_LOAD(INIT_LOAD)) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (strobe),
        .wdata       (bus_wdata),
        .tick_1mhz   (tick_1mhz),
        .hold_in     (hold_in),
        .count_q     (count_q),
        .reload_q    (reload_q),
        .ctrl_q      (ctrl_q),
        .reset_req_q (wd_reset_req)
    );

    assign count_value = count_q;
endmodule

// File: tb/kwdog_top_tb_top.sv
module kwdog_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_1mhz = 1'b0;
    logic        hold_in = 1'b0;
    logic        wd_reset_req;
    logic [31:0] count_value;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    kwdog_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_1mhz(tick_1mhz),
        .hold_in(hold_in), .wd_reset_req(wd_reset_req), .count_value(count_value)
    );

    typedef struct packed {
        logic        rd;
        logic [4:0]  addr;
        logic [31:0] data;
    } vec_t;

    // register-port table, timer disabled throughout
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'h00, 32'h03EF1480},  // R1 count
        '{1'b1, 5'h04, 32'h03EF1480},  // R1 reload
        '{1'b1, 5'h0C, 32'h00000000},  // R1 ctrl
        '{1'b0, 5'h04, 32'h00000100},
        '{1'b1, 5'h04, 32'h00000100},  // R2 reload stored
        '{1'b1, 5'h00, 32'h03EF1480},  // R2 count untouched
        '{1'b0, 5'h00, 32'h12345678},
        '{1'b1, 5'h00, 32'h03EF1480},  // R2 count write ignored
        '{1'b1, 5'h08, 32'h00000000},  // R2 restart reads 0
        '{1'b1, 5'h1C, 32'h00000000},  // R2 unmapped reads 0
        '{1'b0, 5'h08, 32'h00004756},
        '{1'b1, 5'h00, 32'h03EF1480},  // R3 bad key ignored
        '{1'b0, 5'h08, 32'hABCD4755},
        '{1'b1, 5'h00, 32'h00000100},  // R3 key loads reload
        '{1'b0, 5'h0C, 32'h0000003E},
        '{1'b1, 5'h0C, 32'h00000000}   // R4 no flip -> unchanged
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        #1000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R1 req", {31'b0, wd_reset_req}, 32'h0);
        check("R1 count port", count_value, 32'h03EF1480);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) rd("R2/R3/R4 table", VECS[i].addr, VECS[i].data);
            else            wr(VECS[i].addr, VECS[i].data);
        end

        // R5 R6 R7: countdown on peripheral clock
        wr(5'h04, 32'd5);
        wr(5'h0C, 32'h1);
        check("R5 enable loads", count_value, 32'd5);
        idle(4);
        check("R6 step per clock", count_value, 32'd1);
        check("R7 no early req", {31'b0, wd_reset_req}, 32'h0);
        idle(1);
        check("R7 count zero", count_value, 32'd0);
        check("R7 req high", {31'b0, wd_reset_req}, 32'h1);
        idle(1);
        check("R7 req one cycle", {31'b0, wd_reset_req}, 32'h0);
        idle(3);
        check("R7 stays zero", count_value, 32'd0);
        check("R7 no second req", {31'b0, wd_reset_req}, 32'h0);

        // R5 R9: disable freezes, flip beats the step
        wr(5'h04, 32'd10);
        wr(5'h08, 32'h00004755);
        check("R3 restart", count_value, 32'd10);
        idle(2);
        check("R6 counting", count_value, 32'd8);
        wr(5'h0C, 32'h0);
        check("R9 disable beats step", count_value, 32'd8);
        idle(3);
        check("R6 frozen when off", count_value, 32'd8);
        wr(5'h0C, 32'h1);
        check("R5 re-enable reloads", count_value, 32'd10);
        wr(5'h0C, 32'h11);
        check("R4 no-flip keeps count running", count_value, 32'd9);
        rd("R4 no-flip keeps ctrl", 5'h0C, 32'h1);

        // R6: 1 MHz tick selected
        wr(5'h0C, 32'h0);
        wr(5'h0C, 32'h11);
        check("R5 enable tick mode", count_value, 32'd10);
        idle(3);
        check("R6 no tick no step", count_value, 32'd10);
        tick_1mhz = 1'b1;
        idle(1);
        tick_1mhz = 1'b0;
        check("R6 one tick one step", count_value, 32'd9);
        rd("R4 ctrl readback", 5'h0C, 32'h11);

        // R8: hold at expiry
        wr(5'h0C, 32'h0);
        wr(5'h04, 32'd2);
        hold_in = 1'b1;
        wr(5'h0C, 32'h1);
        idle(1);
        check("R8 no req mid", {31'b0, wd_reset_req}, 32'h0);
        idle(1);
        check("R8 count zero", count_value, 32'd0);
        check("R8 no req", {31'b0, wd_reset_req}, 32'h0);
        rd("R8 ctrl cleared", 5'h0C, 32'h0);
        idle(1);
        check("R8 still no req", {31'b0, wd_reset_req}, 32'h0);
        hold_in = 1'b0;

        // R10: zero reload
        wr(5'h04, 32'd0);
        wr(5'h0C, 32'h1);
        check("R10 loads zero", count_value, 32'd0);
        for (int i = 0; i < 3; i++) begin
            idle(1);
            check("R10 no req", {31'b0, wd_reset_req}, 32'h0);
        end

        // R9: restart on the final step
        wr(5'h04, 32'd3);
        wr(5'h08, 32'h00004755);
        check("R3 restart to 3", count_value, 32'd3);
        idle(2);
        check("R9 at one", count_value, 32'd1);
        wr(5'h08, 32'h00004755);
        check("R9 restart beats expiry", count_value, 32'd3);
        check("R9 no req", {31'b0, wd_reset_req}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule